// File: doc/BRIEF.md
# Deferred Arithmetic Flag Store

This block sits beside an integer ALU and keeps just enough state after each operation for any of the six x86-style arithmetic condition flags to be produced later: carry, parity, nibble carry, zero, sign and overflow. On a single-cycle update pulse it takes the two operands, the result the ALU computed, an operation class and an operand size. Operands and result are sign-extended to the full datapath width. Two XOR vectors are then formed from them: an overflow vector and a carry vector. These are registered together with the sign-extended result and a three-bit validity mask.

A consumer such as branch-condition logic reads flags through a combinational port. Each flag comes from one bit extraction on the stored state, or, for zero and parity, from a reduction over it. No opcode decode and no size decode happens on the read side. Increment and decrement take the carry flag currently visible and fold it into the new carry vector. Only one state set is therefore needed. Logical operations clear the validity mask, so carry, overflow and nibble carry read as zero afterwards.

Top module: `lazy_flag_recorder`

## Requirements
- R1: After synchronous reset, and until the first update, every flag reads 0 on both the vector output and the select port.
- R2: State is captured on the clock edge where `upd` is 1. During the cycle of an update, the outputs still show the previous operation's flags. The new flags appear after that edge and hold while `upd` stays 0.
- R3: The operand size code is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Bits of `op_a`, `op_b` and `op_res` above the size are ignored. ZF is 1 when the result is zero within the size, and SF is the result's top bit within the size.
- R4: PF is 1 when bits 7:0 of the result contain an even number of ones.
- R5: For class ADD (0), CF is the unsigned carry out of the operand size. For class SUB (1), CF is the unsigned borrow, meaning A < B within the size.
- R6: OF is the signed overflow within the size. For add, both operands have the same sign and the result's sign differs. For subtract, the operand signs differ and the result's sign differs from A.
- R7: AF is the carry out of bit 3 for add and increment, and the borrow out of bit 3 for subtract and decrement.
- R8: Class LOGIC is 2; the unused codes 5 to 7 behave the same way. For these classes CF, OF and AF read 0, while ZF, SF and PF follow the result.
- R9: INC (3) follows the add rules and DEC (4) follows the subtract rules for ZF, SF, PF, AF and OF. CF keeps the value it had before the operation.
- R10: The select port maps 0 to CF, 1 to PF, 2 to AF, 3 to ZF, 4 to SF and 5 to OF, and codes 6 and 7 return 0. The flag vector `flags_o` uses the same bit positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Record a new operation this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_res | input | W | Result produced by the ALU |
| op_class | input | 3 | Operation class code |
| op_size | input | 2 | Operand size code |
| rd_sel | input | 3 | Flag select for the single-flag read |
| rd_flag | output | 1 | Selected flag |
| flags_o | output | 6 | All six flags, bit 0 CF to bit 5 OF |

## Verification
The bench sweeps byte-sized add and subtract exhaustively over the first operand and across a dense stride of the second, with random junk above bit 7. A design that failed to sign-extend would leak that junk into ZF and SF, and would put CF and OF at the wrong bit. Signed-boundary increments and decrements (0x7F, 0x80, 0xFF, 0x00) are run with CF preset to both values and also after a logical operation. A design that stored a fresh carry for these operations would flip CF, and one that placed the nibble carry at the wrong vector bit would miscompute AF exactly at the 0x0F/0x10 crossings. Checks just before the capturing edge catch any read path that bypasses the register, and the reset check catches a cleared result that would wrongly raise ZF and PF.

// File: rtl/lazy_flags_pkg.sv
package lazy_flags_pkg;

    typedef enum logic [2:0] {
        CLS_ADD   = 3'd0,
        CLS_SUB   = 3'd1,
        CLS_LOGIC = 3'd2,
        CLS_INC   = 3'd3,
        CLS_DEC   = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } op_size_e;

    localparam int NUM_FLAGS = 6;
    localparam int FLAG_CF   = 0;
    localparam int FLAG_PF   = 1;
    localparam int FLAG_AF   = 2;
    localparam int FLAG_ZF   = 3;
    localparam int FLAG_SF   = 4;
    localparam int FLAG_OF   = 5;

    // packed: first member is the MSB, so cf lands on bit 0
    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flag_set_t;

    // which vector-derived flags are meaningful in the stored state
    typedef struct packed {
        logic of;
        logic af;
        logic cf;
    } valid_mask_t;

    function automatic int size_top_bit(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 7;
            SZ_HALF: return 15;
            default: return 31;
        endcase
    endfunction

    function automatic logic class_subtracts(input logic [2:0] cls);
        return (cls == CLS_SUB) || (cls == CLS_DEC);
    endfunction

    function automatic logic class_arith(input logic [2:0] cls);
        return (cls == CLS_ADD) || (cls == CLS_SUB) ||
               (cls == CLS_INC) || (cls == CLS_DEC);
    endfunction

    function automatic logic class_keeps_cf(input logic [2:0] cls);
        return (cls == CLS_INC) || (cls == CLS_DEC);
    endfunction

endpackage

// File: rtl/lf_sizer.sv
module lf_sizer
    import lazy_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] d_in,
    input  logic [1:0]   size_code,
    output logic [W-1:0] a_ext,
    output logic [W-1:0] b_ext,
    output logic [W-1:0] d_ext
);
    // every bit above the operand's sign bit copies that sign bit
    always_comb begin
        int top;
        top = size_top_bit(size_code);
        for (int i = 0; i < W; i++) begin
            a_ext[i] = a_in[(i > top) ? top : i];
            b_ext[i] = b_in[(i > top) ? top : i];
            d_ext[i] = d_in[(i > top) ? top : i];
        end
    end

    initial begin
        if (W < 32) $error("lf_sizer needs W >= 32");
    end
endmodule

// File: rtl/lf_vector_gen.sv
module lf_vector_gen
    import lazy_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_ext,
    input  logic [W-1:0] b_ext,
    input  logic [W-1:0] d_ext,
    input  logic [2:0]   cls,
    input  logic         cf_now,
    output logic [W-1:0] ovec,
    output logic [W-1:0] cvec,
    output valid_mask_t  mask
);
    logic [W-1:0] ab_x;
    logic [W-1:0] ad_x;
    logic [W-1:0] cvec_raw;

    always_comb begin
        ab_x = a_ext ^ b_ext;
        ad_x = a_ext ^ d_ext;
        if (class_subtracts(cls))
            ovec = ad_x & ab_x;
        else
            ovec = ad_x & ~ab_x;
        // bit i of this vector is the carry (or borrow) out of bit i
        cvec_raw = ab_x ^ d_ext ^ ovec;
        if (class_keeps_cf(cls))
            cvec = {cf_now, cvec_raw[W-2:0]};
        else
            cvec = cvec_raw;
        mask = class_arith(cls) ? 3'b111 : 3'b000;
    end
endmodule

// File: rtl/lf_state_reg.sv
module lf_state_reg
    import lazy_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [W-1:0] res_d,
    input  logic [W-1:0] ovec_d,
    input  logic [W-1:0] cvec_d,
    input  valid_mask_t  mask_d,
    output logic [W-1:0] res_q,
    output logic [W-1:0] ovec_q,
    output logic [W-1:0] cvec_q,
    output valid_mask_t  mask_q
);
    // a reset result of 1 is non-zero, positive and of odd parity,
    // so ZF, SF and PF all read 0 without a separate empty bit
    localparam logic [W-1:0] RES_RESET = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= RES_RESET;
            ovec_q <= '0;
            cvec_q <= '0;
            mask_q <= '0;
        end else if (upd) begin
            res_q  <= res_d;
            ovec_q <= ovec_d;
            cvec_q <= cvec_d;
            mask_q <= mask_d;
        end
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        upd |=> (res_q == $past(res_d)) && (cvec_q == $past(cvec_d)) &&
                (ovec_q == $past(ovec_d)) && (mask_q == $past(mask_d)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(res_q) && $stable(cvec_q) && $stable(ovec_q) && $stable(mask_q));
endmodule

// File: rtl/lf_flag_read.sv
module lf_flag_read
    import lazy_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res_q,
    input  logic [W-1:0] ovec_q,
    input  logic [W-1:0] cvec_q,
    input  valid_mask_t  mask_q,
    input  logic [2:0]   sel,
    output flag_set_t    flags,
    output logic         sel_flag
);
    localparam int TOP    = W - 1;
    localparam int NIB_CO = 3;

    always_comb begin
        flags.cf = mask_q.cf & cvec_q[TOP];
        flags.af = mask_q.af & cvec_q[NIB_CO];
        flags.of = mask_q.of & ovec_q[TOP];
        flags.zf = (res_q == '0);
        flags.sf = res_q[TOP];
        flags.pf = ~^res_q[7:0];
    end

    always_comb begin
        case (int'(sel))
            FLAG_CF: sel_flag = flags.cf;
            FLAG_PF: sel_flag = flags.pf;
            FLAG_AF: sel_flag = flags.af;
            FLAG_ZF: sel_flag = flags.zf;
            FLAG_SF: sel_flag = flags.sf;
            FLAG_OF: sel_flag = flags.of;
            default: sel_flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/lazy_flag_recorder.sv
module lazy_flag_recorder
    import lazy_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    input  logic [W-1:0]         op_res,
    input  logic [2:0]           op_class,
    input  logic [1:0]           op_size,
    input  logic [2:0]           rd_sel,
    output logic                 rd_flag,
    output logic [NUM_FLAGS-1:0] flags_o
);
    logic [W-1:0] a_ext, b_ext, d_ext;
    logic [W-1:0] ovec_d, cvec_d;
    logic [W-1:0] res_q, ovec_q, cvec_q;
    valid_mask_t  mask_d, mask_q;
    flag_set_t    flags;

    lf_sizer #(.W(W)) u_sizer (
        .a_in(op_a), .b_in(op_b), .d_in(op_res), .size_code(op_size),
        .a_ext(a_ext), .b_ext(b_ext), .d_ext(d_ext)
    );

    lf_vector_gen #(.W(W)) u_vec (
        .a_ext(a_ext), .b_ext(b_ext), .d_ext(d_ext), .cls(op_class),
        .cf_now(flags.cf), .ovec(ovec_d), .cvec(cvec_d), .mask(mask_d)
    );

    lf_state_reg #(.W(W)) u_state (
        .clk(clk), .rst(rst), .upd(upd),
        .res_d(d_ext), .ovec_d(ovec_d), .cvec_d(cvec_d), .mask_d(mask_d),
        .res_q(res_q), .ovec_q(ovec_q), .cvec_q(cvec_q), .mask_q(mask_q)
    );

    lf_flag_read #(.W(W)) u_read (
        .res_q(res_q), .ovec_q(ovec_q), .cvec_q(cvec_q), .mask_q(mask_q),
        .sel(rd_sel), .flags(flags), .sel_flag(rd_flag)
    );

    assign flags_o = flags;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags_o == '0));

    p_zero_consistent_r3: assert property (@(posedge clk) disable iff (rst)
        flags_o[FLAG_ZF] |-> (!flags_o[FLAG_SF] && flags_o[FLAG_PF]));

    p_logic_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (upd && !class_arith(op_class)) |=>
            (!flags_o[FLAG_CF] && !flags_o[FLAG_OF] && !flags_o[FLAG_AF]));

    p_incdec_keeps_cf_r9: assert property (@(posedge clk) disable iff (rst)
        (upd && class_keeps_cf(op_class)) |=> (flags_o[FLAG_CF] == $past(flags_o[FLAG_CF])));

    p_sel_unused_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_sel > 3'd5) |-> !rd_flag);
endmodule

// File: tb/lazy_flag_recorder_test.sv
`timescale 1ns/1ps
module lazy_flag_recorder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_res = '0;
    logic [2:0]  op_class = '0;
    logic [1:0]  op_size = '0;
    logic [2:0]  rd_sel = '0;
    logic        rd_flag;
    logic [5:0]  flags_o;

    int compared = 0;
    int mismatched = 0;
    logic cf_track = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    lazy_flag_recorder #(.W(32)) uut (
        .clk(clk), .rst(rst), .upd(upd), .op_a(op_a), .op_b(op_b),
        .op_res(op_res), .op_class(op_class), .op_size(op_size),
        .rd_sel(rd_sel), .rd_flag(rd_flag), .flags_o(flags_o)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // reference: flags bit0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input int cls, input int sz, input logic cfp,
                                  output logic [31:0] d, output logic [5:0] f);
        int n;
        longint unsigned m, an, bn, r;
        logic cf, af, of, sa, sb, sr;
        n  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        m  = (64'd1 << n) - 64'd1;
        an = 64'(a) & m;
        bn = 64'(b) & m;
        sa = 1'((an >> (n - 1)) & 64'd1);
        sb = 1'((bn >> (n - 1)) & 64'd1);
        cf = 1'b0; af = 1'b0; of = 1'b0;
        if (cls == 0 || cls == 3) begin
            d  = a + b;
            r  = (an + bn) & m;
            sr = 1'((r >> (n - 1)) & 64'd1);
            cf = (cls == 3) ? cfp : (an + bn > m);
            af = ((an & 64'd15) + (bn & 64'd15)) > 64'd15;
            of = (sa == sb) && (sr != sa);
        end else if (cls == 1 || cls == 4) begin
            d  = a - b;
            r  = (an - bn) & m;
            sr = 1'((r >> (n - 1)) & 64'd1);
            cf = (cls == 4) ? cfp : (an < bn);
            af = (an & 64'd15) < (bn & 64'd15);
            of = (sa != sb) && (sr != sa);
        end else begin
            d  = a ^ b;
            r  = (an ^ bn) & m;
            sr = 1'((r >> (n - 1)) & 64'd1);
        end
        f = {of, sr, (r == 64'd0), af, ~^r[7:0], cf};
    endfunction

    task automatic check6(input logic [5:0] got, input logic [5:0] exp, input string req);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s flags got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check1(input logic got, input logic exp, input string req);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s rd_flag got %b expected %b (sel %0d)", req, got, exp, rd_sel);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input int cls, input int sz, input string req);
        logic [31:0] d;
        logic [5:0]  f;
        model(a, b, cls, sz, cf_track, d, f);
        @(negedge clk);
        upd = 1'b1; op_a = a; op_b = b; op_res = d;
        op_class = cls[2:0]; op_size = sz[1:0];
        @(posedge clk);
        #1;
        upd = 1'b0;
        check6(flags_o, f, req);
        cf_track = f[0];
    endtask

    task automatic sweep_sel(input logic [5:0] exp, input string req);
        for (int s = 0; s < 8; s++) begin
            rd_sel = s[2:0];
            #1;
            check1(rd_flag, (s < 6) ? exp[s] : 1'b0, req);
        end
        rd_sel = '0;
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] d0;
        logic [5:0]  f0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check6(flags_o, 6'b0, "R1");
        sweep_sel(6'b0, "R1");

        // R2: same-cycle read still shows old state; new state after the edge
        model(32'h80, 32'h80, 0, 0, cf_track, d0, f0);
        @(negedge clk);
        upd = 1'b1; op_a = 32'h80; op_b = 32'h80; op_res = d0;
        op_class = 3'd0; op_size = 2'd0;
        #2;
        check6(flags_o, 6'b0, "R2");
        @(posedge clk);
        #1;
        upd = 1'b0;
        check6(flags_o, f0, "R2");
        cf_track = f0[0];
        repeat (2) @(posedge clk);
        #1;
        check6(flags_o, f0, "R2");
        // R10: read port over a non-trivial state
        sweep_sel(f0, "R10");

        // R3 R4 R5 R6 R7: byte add/sub with junk above the size
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 3) begin
                seed = next_rand(seed);
                run_op({seed[31:8], a[7:0]}, {seed[23:0], b[7:0]}, 0, 0, "R5");
                run_op({seed[15:0], 8'h5a, a[7:0]}, {seed[31:8], b[7:0]}, 1, 0, "R6");
            end
        end

        // R9: increment/decrement edges with both prior CF values
        for (int c = 0; c < 2; c++) begin
            if (c == 0) run_op(32'h0, 32'h1, 1, 0, "R9");
            else        run_op(32'h5, 32'h1, 1, 0, "R9");
            run_op(32'h7f, 32'h1, 3, 0, "R9");
            run_op(32'hff, 32'h1, 3, 0, "R9");
            run_op(32'h80, 32'h1, 4, 0, "R9");
            run_op(32'h00, 32'h1, 4, 0, "R9");
            run_op(32'h0f, 32'h1, 3, 0, "R7");
            run_op(32'h10, 32'h1, 4, 0, "R7");
            run_op(32'h7fff, 32'h1, 3, 1, "R9");
            run_op(32'h8000_0000, 32'h1, 4, 2, "R9");
        end
        // R8 then R9: logic clears CF, INC must keep it clear
        run_op(32'hffff_ffff, 32'h1, 0, 2, "R5");
        run_op(32'hf0f0_f0f0, 32'h0f0f_0f0f, 2, 2, "R8");
        run_op(32'hffff_ffff, 32'h1, 3, 2, "R9");
        run_op(32'h1234, 32'h1234, 2, 1, "R8");
        run_op(32'h55, 32'h12, 7, 0, "R8");

        // R3..R9: random 16- and 32-bit traffic over all classes
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra, rb;
            int cls, sz;
            seed = next_rand(seed); ra = seed;
            seed = next_rand(seed); rb = seed;
            cls = int'(seed[10:8]) % 5;
            sz  = (i % 2 == 0) ? 1 : (seed[3] ? 2 : 3);
            if (cls >= 3) rb = 32'h1;
            if (i % 7 == 0) ra = (sz == 1) ? {ra[31:16], 16'h8000} : 32'h7fff_ffff;
            run_op(ra, rb, cls, sz, "R3");
        end

        // R10: select port after a logical op with a negative byte result
        model(32'h0, 32'h83, 2, 0, cf_track, d0, f0);
        run_op(32'h0, 32'h83, 2, 0, "R4");
        sweep_sel(f0, "R10");

        // R1: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check6(flags_o, 6'b0, "R1");
        cf_track = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule